// File: doc/BRIEF.md
# Bilateral Grid Accumulation Unit

This unit takes a grayscale frame that arrives as a stream, one pixel per clock, and bins it into a coarse three-dimensional grid held in on-chip RAM. The grid is the first stage of a bilateral-grid edge-preserving smoother. Each pixel lands in exactly one cell, chosen by quantizing its column, its row and its intensity. Every cell keeps a running sum of intensities and a pixel count, so that a later normalizing stage can form averages. The spatial cell edge is a run-time radius `r` in pixels, used on both axes. The intensity axis is cut into a fixed number of bins.

The frame is scanned down each column, so the `r` vertically adjacent pixels that share a cell arrive back to back. A merge register adds these runs together before any RAM traffic takes place. Only when the cell changes is the merged partial sum sent to a pipelined read-modify-write path. That path forwards its own recent writes, so it never stalls. A start-of-frame pulse first sweeps every cell to zero. An end-of-frame pulse drains the last partial sum and raises a done flag. After done, the grid is read through a simple address/data port.

Top module: `bg_grid_accum`

## Requirements
- R1: A `sof` pulse starts a clear sweep. `busy` is high for exactly 256 consecutive cycles, beginning in the cycle after `sof`. After the sweep, every cell that the new frame does not touch reads back as zero.
- R2: Pixels presented while `busy` is high, or after `eof` until the next `sof`, change no cell.
- R3: Position is counted inside the unit in column-major order. The k-th accepted pixel of a frame has column k/16 and row k mod 16 in a 16x16 frame. A cycle with `px_valid` low does not advance the position.
- R4: A pixel goes to cell cx = column / r, cy = row / r, bin = intensity >> 6. That cell lives at address (cx*8 + cy)*4 + bin.
- R5: The radius is sampled from `rad_in` when `sof` is seen, and later changes to `rad_in` have no effect on the frame. A value below 2 acts as 2, and a value above 8 acts as 8.
- R6: `rd_data` holds the intensity sum in bits [20:7] and the pixel count in bits [6:0]. A full-scale 8x8 cell (sum 16320, count 64) is stored without wrap.
- R7: With `px_valid` held high, a pixel is accepted on every clock of the accumulation phase. There is no stall.
- R8: A cell that is updated again while its previous update is still in the read-modify-write pipeline ends with the correct total.
- R9: `done` rises within 8 cycles of `eof`. It stays high until the next `sof`, and it is low after `sof`.
- R10: `rd_data` shows the cell at `rd_addr` one clock after the address is applied.
- R11: After reset, `busy` and `done` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; starts the clear sweep |
| eof | input | 1 | End-of-frame pulse; drains the last partial sum |
| rad_in | input | 4 | Spatial cell edge in pixels, sampled at `sof` |
| px_valid | input | 1 | Pixel strobe |
| px_data | input | 8 | Pixel intensity |
| busy | output | 1 | Clear sweep in progress |
| done | output | 1 | Grid complete and readable |
| rd_addr | input | 8 | Readout cell address |
| rd_data | output | 21 | Readout cell: {sum, count} |

## Verification
The hardest case to reach from the ports is a cell that is flushed again two flushes after its earlier flush. At that moment the earlier write has not yet landed in RAM, so the RAM read returns a stale value and only the write-history forward keeps the total right. The stimulus reaches this with a frame whose intensities alternate between two bins on every pixel. That forces a flush on every clock and brings each cell back exactly two flushes later. Random frames with idle gaps and clamped radii, plus a full-scale frame at the largest radius, cover the rest.

// File: rtl/bg_pkg.sv
package bg_pkg;
    localparam int IMG_W     = 16;
    localparam int IMG_H     = 16;
    localparam int PIX_W     = 8;
    localparam int BIN_SHIFT = 6;
    localparam int R_MIN     = 2;
    localparam int R_MAX     = 8;

    localparam int RAD_W  = $clog2(R_MAX + 1);
    localparam int BIN_W  = PIX_W - BIN_SHIFT;
    localparam int BINS   = 1 << BIN_W;
    localparam int GX     = (IMG_W + R_MIN - 1) / R_MIN;
    localparam int GY     = (IMG_H + R_MIN - 1) / R_MIN;
    localparam int NCELLS = GX * GY * BINS;
    localparam int ADDR_W = $clog2(NCELLS);
    localparam int COL_W  = $clog2(IMG_W);
    localparam int ROW_W  = $clog2(IMG_H);
    localparam int CX_W   = $clog2(GX);
    localparam int CY_W   = $clog2(GY);
    localparam int CNT_W  = $clog2(R_MAX * R_MAX + 1);
    localparam int SUM_W  = PIX_W + $clog2(R_MAX * R_MAX);
    localparam int CELL_W = SUM_W + CNT_W;

    typedef struct packed {
        logic [CX_W-1:0]  cx;
        logic [CY_W-1:0]  cy;
        logic [BIN_W-1:0] bin;
    } cell_key_t;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
    } cell_val_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_ACCUM,
        PH_DRAIN,
        PH_DONE
    } phase_t;

    function automatic logic [ADDR_W-1:0] key_addr(cell_key_t k);
        int a;
        a = (int'(k.cx) * GY + int'(k.cy)) * BINS + int'(k.bin);
        return ADDR_W'(a);
    endfunction

    function automatic logic [RAD_W-1:0] clamp_rad(logic [RAD_W-1:0] r);
        if (int'(r) < R_MIN) return RAD_W'(R_MIN);
        if (int'(r) > R_MAX) return RAD_W'(R_MAX);
        return r;
    endfunction
endpackage

// File: rtl/bg_pos_track.sv
module bg_pos_track
    import bg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            step,
    input  logic [RAD_W-1:0] rad,
    output logic [CX_W-1:0] cx,
    output logic [CY_W-1:0] cy
);
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [RAD_W-1:0] sx, sy;
    logic [RAD_W-1:0] rad_last;

    assign rad_last = rad - RAD_W'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            col <= '0;
            row <= '0;
            sx  <= '0;
            sy  <= '0;
            cx  <= '0;
            cy  <= '0;
        end else if (step) begin
            if (row == ROW_W'(IMG_H - 1)) begin
                row <= '0;
                sy  <= '0;
                cy  <= '0;
                if (col == COL_W'(IMG_W - 1)) begin
                    col <= '0;
                    sx  <= '0;
                    cx  <= '0;
                end else begin
                    col <= col + COL_W'(1);
                    if (sx == rad_last) begin
                        sx <= '0;
                        cx <= cx + CX_W'(1);
                    end else begin
                        sx <= sx + RAD_W'(1);
                    end
                end
            end else begin
                row <= row + ROW_W'(1);
                if (sy == rad_last) begin
                    sy <= '0;
                    cy <= cy + CY_W'(1);
                end else begin
                    sy <= sy + RAD_W'(1);
                end
            end
        end
    end

    // R4: sub-cell offsets always stay inside the current window
    a_r4_offset_in_window: assert property (@(posedge clk) disable iff (rst)
        (sx < rad) && (sy < rad));
endmodule

// File: rtl/bg_run_merge.sv
module bg_run_merge
    import bg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kill,
    input  logic              take,
    input  cell_key_t         px_key,
    input  logic [PIX_W-1:0]  px_val,
    input  logic              drain,
    output logic              fl_v,
    output logic [ADDR_W-1:0] fl_addr,
    output cell_val_t         fl_add
);
    logic      acc_v;
    cell_key_t acc_key;
    cell_val_t acc;
    logic      same_cell;

    assign same_cell = acc_v && (px_key == acc_key);
    assign fl_v      = acc_v && ((take && !same_cell) || drain);
    assign fl_addr   = key_addr(acc_key);
    assign fl_add    = acc;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            acc_v <= 1'b0;
        end else if (take) begin
            acc_v <= 1'b1;
        end else if (drain) begin
            acc_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            if (same_cell) begin
                acc.sum <= acc.sum + SUM_W'(px_val);
                acc.cnt <= acc.cnt + CNT_W'(1);
            end else begin
                acc.sum <= SUM_W'(px_val);
                acc.cnt <= CNT_W'(1);
                acc_key <= px_key;
            end
        end
    end

    // R7: a flushed partial sum always carries at least one pixel
    a_r7_flush_nonempty: assert property (@(posedge clk) disable iff (rst)
        fl_v |-> (fl_add.cnt != '0));

    // R8: two flushes in a row never target the same cell
    a_r8_flush_cell_changes: assert property (@(posedge clk) disable iff (rst)
        (fl_v && $past(fl_v) && !$past(kill)) |-> (fl_addr != $past(fl_addr)));
endmodule

// File: rtl/bg_grid_store.sv
module bg_grid_store
    import bg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kill,
    input  logic              fl_v,
    input  logic [ADDR_W-1:0] fl_addr,
    input  cell_val_t         fl_add,
    input  logic              clr_we,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output cell_val_t         rd_cell,
    output logic              pipe_busy
);
    cell_val_t mem [NCELLS];

    logic              s1_v, s2_v, wb1_v, wb2_v;
    logic [ADDR_W-1:0] s1_a, s2_a, wb1_a, wb2_a;
    cell_val_t         s1_d, s2_d, q1, q2, wb1_d, wb2_d;
    cell_val_t         base, upd;

    assign pipe_busy = s1_v | s2_v;

    always_comb begin
        base = q2;
        if (wb2_v && (wb2_a == s2_a)) base = wb2_d;
        if (wb1_v && (wb1_a == s2_a)) base = wb1_d;
        upd.sum = base.sum + s2_d.sum;
        upd.cnt = base.cnt + s2_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            s1_v  <= 1'b0;
            s2_v  <= 1'b0;
            wb1_v <= 1'b0;
            wb2_v <= 1'b0;
        end else begin
            s1_v  <= fl_v;
            s2_v  <= s1_v;
            wb1_v <= s2_v;
            wb2_v <= wb1_v;
        end
    end

    always_ff @(posedge clk) begin
        s1_a    <= fl_addr;
        s1_d    <= fl_add;
        q1      <= mem[fl_addr];
        s2_a    <= s1_a;
        s2_d    <= s1_d;
        q2      <= q1;
        wb1_a   <= s2_a;
        wb1_d   <= upd;
        wb2_a   <= wb1_a;
        wb2_d   <= wb1_d;
        rd_cell <= mem[rd_addr];
        if (clr_we) begin
            mem[clr_addr] <= '0;
        end else if (s2_v) begin
            mem[s2_a] <= upd;
        end
    end

    // R6: a cell never holds more than R_MAX*R_MAX pixels
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        s2_v |-> (int'(upd.cnt) <= R_MAX * R_MAX));

    // R6: adding a partial sum never wraps the stored sum
    a_r6_no_sum_wrap: assert property (@(posedge clk) disable iff (rst)
        s2_v |-> (upd.sum >= s2_d.sum));

    // R1: the clear sweep never overlaps a pending update write
    a_r1_clear_exclusive: assert property (@(posedge clk) disable iff (rst)
        clr_we |-> !s2_v);
endmodule

// File: rtl/bg_grid_accum.sv
module bg_grid_accum
    import bg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              eof,
    input  logic [RAD_W-1:0]  rad_in,
    input  logic              px_valid,
    input  logic [PIX_W-1:0]  px_data,
    output logic              busy,
    output logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CELL_W-1:0] rd_data
);
    phase_t            phase;
    logic [ADDR_W-1:0] clr_addr;
    logic [RAD_W-1:0]  rad_q;
    logic              take, drain, pipe_busy;
    logic [CX_W-1:0]   cur_cx;
    logic [CY_W-1:0]   cur_cy;
    cell_key_t         px_key;
    logic              fl_v;
    logic [ADDR_W-1:0] fl_addr;
    cell_val_t         fl_add;
    cell_val_t         rd_cell;

    assign busy    = (phase == PH_CLEAR);
    assign done    = (phase == PH_DONE);
    assign take    = px_valid && (phase == PH_ACCUM) && !eof && !sof;
    assign drain   = eof && (phase == PH_ACCUM) && !sof;
    assign px_key  = '{cx: cur_cx, cy: cur_cy, bin: px_data[PIX_W-1:BIN_SHIFT]};
    assign rd_data = rd_cell;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            clr_addr <= '0;
            rad_q    <= RAD_W'(R_MIN);
        end else if (sof) begin
            phase    <= PH_CLEAR;
            clr_addr <= '0;
            rad_q    <= clamp_rad(rad_in);
        end else begin
            case (phase)
                PH_CLEAR: begin
                    if (clr_addr == ADDR_W'(NCELLS - 1)) phase <= PH_ACCUM;
                    else clr_addr <= clr_addr + ADDR_W'(1);
                end
                PH_ACCUM: if (eof) phase <= PH_DRAIN;
                PH_DRAIN: if (!pipe_busy) phase <= PH_DONE;
                default: ;
            endcase
        end
    end

    bg_pos_track u_pos (
        .clk     (clk),
        .rst     (rst),
        .restart (sof),
        .step    (take),
        .rad     (rad_q),
        .cx      (cur_cx),
        .cy      (cur_cy)
    );

    bg_run_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .kill    (sof),
        .take    (take),
        .px_key  (px_key),
        .px_val  (px_data),
        .drain   (drain),
        .fl_v    (fl_v),
        .fl_addr (fl_addr),
        .fl_add  (fl_add)
    );

    bg_grid_store u_store (
        .clk       (clk),
        .rst       (rst),
        .kill      (sof),
        .fl_v      (fl_v),
        .fl_addr   (fl_addr),
        .fl_add    (fl_add),
        .clr_we    (busy),
        .clr_addr  (clr_addr),
        .rd_addr   (rd_addr),
        .rd_cell   (rd_cell),
        .pipe_busy (pipe_busy)
    );

    // R9: done holds until a new frame starts
    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !sof) |=> done);

    // R1: the sweep keeps going until the last cell is cleared
    a_r1_sweep_complete: assert property (@(posedge clk) disable iff (rst)
        (busy && !sof && (clr_addr != ADDR_W'(NCELLS - 1))) |=> busy);

    // R2: no RAM update is requested while clearing or after completion
    a_r2_no_flush_outside_frame: assert property (@(posedge clk) disable iff (rst)
        (busy || done) |-> !fl_v);
endmodule

// File: tb/tb_bg_grid_accum.sv
module tb_bg_grid_accum;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0;
    logic        eof = 1'b0;
    logic [3:0]  rad_in = 4'd2;
    logic        px_valid = 1'b0;
    logic [7:0]  px_data = 8'd0;
    logic        busy, done;
    logic [7:0]  rd_addr = 8'd0;
    logic [20:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int pix [256];
    int exp_sum [256];
    int exp_cnt [256];

    always #10 clk = ~clk;

    bg_grid_accum dut (
        .clk(clk), .rst(rst), .sof(sof), .eof(eof), .rad_in(rad_in),
        .px_valid(px_valid), .px_data(px_data), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_rad(input int r);
        if (r < 2) return 2;
        if (r > 8) return 8;
        return r;
    endfunction

    task automatic build_expect(input int r_raw);
        int r;
        r = eff_rad(r_raw);
        for (int a = 0; a < 256; a++) begin
            exp_sum[a] = 0;
            exp_cnt[a] = 0;
        end
        for (int k = 0; k < 256; k++) begin
            int col, row, a;
            col = k / 16;
            row = k % 16;
            a = ((col / r) * 8 + (row / r)) * 4 + (pix[k] >> 6);
            exp_sum[a] += pix[k];
            exp_cnt[a] += 1;
        end
    endtask

    // One frame: sof, clear sweep, pixels, eof, wait for done, readout of all cells.
    task automatic run_frame(input int r_raw, input int gap_pct, input bit junk, input string tag);
        int n;
        int w;
        build_expect(r_raw);
        sof = 1'b1;
        rad_in = 4'(r_raw);
        @(negedge clk);
        sof = 1'b0;
        rad_in = 4'($urandom % 16);  // R5: must not matter after sof
        check(done == 1'b0, "R9 done low after sof", int'(done), 0);
        n = 0;
        while (busy && n < 1000) begin
            px_valid = junk;            // R2: ignored while clearing
            px_data  = 8'($urandom);
            n++;
            @(negedge clk);
        end
        px_valid = 1'b0;
        check(n == 256, {"R1 busy length ", tag}, n, 256);
        for (int k = 0; k < 256; k++) begin
            while (int'($urandom % 100) < gap_pct) begin
                px_valid = 1'b0;        // R3: idle cycles do not advance position
                @(negedge clk);
            end
            px_valid = 1'b1;
            px_data  = 8'(pix[k]);
            @(negedge clk);
        end
        px_valid = 1'b0;
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        w = 1;
        while (!done && w < 20) begin
            @(negedge clk);
            w++;
        end
        check(done == 1'b1 && w <= 8, {"R9 done after eof ", tag}, w, 8);
        for (int j = 0; j < 6; j++) begin
            px_valid = 1'b1;            // R2: ignored after eof
            px_data  = 8'($urandom);
            @(negedge clk);
        end
        px_valid = 1'b0;
        check(done == 1'b1, {"R9 done holds ", tag}, int'(done), 1);
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            @(negedge clk);             // R10: one-cycle read latency
            if (int'(rd_data[20:7]) != exp_sum[a])
                check(1'b0, {"R4 R6 R8 cell sum ", tag}, int'(rd_data[20:7]), exp_sum[a]);
            else
                check(1'b1, "R4 cell sum", 0, 0);
            if (int'(rd_data[6:0]) != exp_cnt[a])
                check(1'b0, {"R3 R7 cell count ", tag}, int'(rd_data[6:0]), exp_cnt[a]);
            else
                check(1'b1, "R3 cell count", 0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(20211));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R11 done after reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3/R4: random intensities, idle gaps, junk while busy, r=2
        for (int k = 0; k < 256; k++) pix[k] = int'($urandom % 256);
        run_frame(2, 20, 1'b1, "random r2");

        // R6: full scale at the largest radius; R1: old cells must be cleared
        for (int k = 0; k < 256; k++) pix[k] = 255;
        run_frame(8, 0, 1'b0, "fullscale r8");

        // R8: bins alternate every pixel so cells return while in flight
        for (int k = 0; k < 256; k++) pix[k] = (k % 2 == 0) ? 10 : 200;
        run_frame(3, 0, 1'b0, "alternate r3");

        // R5: radius below range clamps to 2; R7: no gaps
        for (int k = 0; k < 256; k++) pix[k] = int'($urandom % 256);
        run_frame(0, 0, 1'b0, "clamp low");

        // R5: radius above range clamps to 8
        for (int k = 0; k < 256; k++) pix[k] = int'($urandom % 256);
        run_frame(15, 10, 1'b1, "clamp high");

        // R7: long same-cell runs merged, three bins in the mix
        for (int k = 0; k < 256; k++) pix[k] = ((k / 16) * 37) % 192;
        run_frame(5, 0, 1'b0, "runs r5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule